// File: doc/BRIEF.md
# Byte-Addressed I2C Register-Map Slave

This block is the serial front end of a timekeeping register file. It watches the SCL and SDA lines through a short synchronizer chain clocked by the system clock. On those lines it finds bus conditions, accepts its own 7-bit device address and keeps a byte pointer into a 160-byte map. The map holds clock/calendar bytes at 00h–07h, control and identity bytes at 08h–1Fh and general RAM at 20h–9Fh. The storage itself sits outside the block. The block issues single-cycle read and write strobes against `reg_addr` and drives SDA low only through the open-drain enable `sda_oe`.

A master writes by sending the device address with R/W=0, then the word address and then data bytes. It reads either at once, from wherever the pointer stands, or after a word-address write followed by a repeated START with R/W=1. The pointer moves forward only on the acknowledge clock that follows each data byte. While a selected transfer has the pointer inside the clock range, `clk_freeze` tells the timekeeper to stop copying live time into the visible registers. A power-fail level aborts everything.

The controller is one state machine. Its states are **ST_IDLE**, **ST_DEVADR** (shift in the device byte), **ST_DEVACK** (acknowledge it), **ST_WORD** (shift in the word address), **ST_WORDACK**, **ST_WDATA** (shift in a data byte), **ST_WDACK**, **ST_RDATA** (shift out a byte) and **ST_RDACK** (master acknowledge slot). Each arc below is the result of the named event:
- Any state: STOP or power fail goes to ST_IDLE, and START goes to ST_DEVADR.
- ST_DEVADR: the 8th SCL fall goes to ST_DEVACK on an address match, and to ST_IDLE otherwise.
- ST_DEVACK: the SCL fall goes to ST_RDATA when R/W=1, and to ST_WORD otherwise.
- ST_WORD: the 8th fall goes to ST_WORDACK.
- ST_WORDACK: the SCL fall goes to ST_WDATA.
- ST_WDATA: the 8th fall goes to ST_WDACK.
- ST_WDACK: the SCL fall goes to ST_WDATA.
- ST_RDATA: the 8th fall goes to ST_RDACK.
- ST_RDACK: the SCL fall goes to ST_RDATA after a master ACK, and to ST_IDLE after a NACK.

Top module: `i2c_regfile_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and it always restarts address reception, including in the middle of a transfer (repeated START). A STOP is SDA rising while SCL is high, and it returns the block to idle.
- R2: The block acknowledges a device byte whose upper seven bits equal 68h (D0h for write, D1h for read). Any other device byte gets no acknowledge, and the bus is then ignored until the next START.
- R3: In a write, the word-address byte and every data byte are acknowledged. Each accepted data byte produces one single-cycle `reg_wr` pulse carrying the byte on `reg_wdata` at the current `reg_addr`.
- R4: The pointer advances by exactly one on the 9th (acknowledge) SCL rise after each data byte, in both directions, whatever level the master gives in a read acknowledge slot.
- R5: After a word-address write, a repeated START with R/W=1 returns the byte at that word address first, then consecutive bytes.
- R6: A read started with no word-address write returns the byte at the pointer's current value.
- R7: When the master does not acknowledge a read byte, SDA is released and the block goes idle.
- R8: The pointer wraps from 9Fh to 00h. A word address of A0h or above loads 00h.
- R9: Data bytes addressed to 10h–12h or 16h–1Fh are acknowledged and advance the pointer, but raise no `reg_wr`.
- R10: `clk_freeze` is high while a transfer addressed to this slave is open and the pointer is below 08h. It drops on STOP, on a read NACK or once the pointer reaches 08h or above.
- R11: While `pwr_fail` is high, the transfer in progress is aborted, the pointer is cleared to 00h, SDA is released, `clk_freeze` is low and bus activity is ignored.
- R12: After reset the pointer is 00h, SDA is released and `clk_freeze` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_addr | output | 8 | Byte pointer, address of every strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data accompanying reg_wr |
| reg_rd | output | 1 | One-cycle fetch strobe; reg_rdata is taken at the end of that cycle |
| reg_rdata | input | 8 | Byte at reg_addr from the register file |
| clk_freeze | output | 1 | Hold visible clock registers |

## Verification
The bench uses the default parameters: device address 68h, a 160-byte map, a freeze boundary of 08h and two synchronizer stages. With these values, short directed transfers reach the 9Fh-to-00h wrap, an out-of-range word address and both protected windows. A write that starts at 06h crosses the freeze boundary in two bytes, so the drop of `clk_freeze` is observed between acknowledge clocks. A power-fail pulse is raised partway through a write, and the bytes sent afterwards show that the bus is ignored.

// File: rtl/i2c_rf_pkg.sv
`timescale 1ns/1ps
package i2c_rf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_WORD,
        ST_WORDACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RDACK
    } bus_state_e;

    // locations that accept no write: a reserved window and the identity window
    localparam logic [7:0] LOCK_A_LO = 8'h10;
    localparam logic [7:0] LOCK_A_HI = 8'h12;
    localparam logic [7:0] LOCK_B_LO = 8'h16;
    localparam logic [7:0] LOCK_B_HI = 8'h1F;

    function automatic logic byte_writable(input logic [7:0] a);
        return !((a >= LOCK_A_LO && a <= LOCK_A_HI) ||
                 (a >= LOCK_B_LO && a <= LOCK_B_HI));
    endfunction

endpackage

// File: rtl/i2c_line_cond.sv
`timescale 1ns/1ps
module i2c_line_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_now  = scl_sh[STAGES-1];
    assign sda_lvl  = sda_sh[STAGES-1];
    assign scl_rise = scl_now & ~scl_q;
    assign scl_fall = ~scl_now & scl_q;
    assign start_c  = scl_now & scl_q & sda_q & ~sda_lvl;
    assign stop_c   = scl_now & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_ptr.sv
`timescale 1ns/1ps
module i2c_ptr #(
    parameter int MEM_BYTES = 160,
    parameter int AW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [7:0]    load_val,
    input  logic          bump,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (load)
            ptr <= (int'(load_val) < MEM_BYTES) ? AW'(load_val) : '0;
        else if (bump)
            ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
    end

endmodule

// File: rtl/i2c_regfile_slave.sv
`timescale 1ns/1ps
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR   = 7'h68,
    parameter int         MEM_BYTES  = 160,
    parameter int         FREEZE_TOP = 8,
    parameter int         SYNC_LEN   = 2,
    localparam int        AW         = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          pwr_fail,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    output logic          reg_wr,
    output logic [7:0]    reg_wdata,
    output logic          reg_rd,
    input  logic [7:0]    reg_rdata,
    output logic          clk_freeze
);
    bus_state_e state, nxt;

    logic       sda_lvl, scl_rise, scl_fall, start_c, stop_c;
    logic [3:0] bit_cnt;
    logic [7:0] shreg, txreg, hold, wdata_q;
    logic       mack, sel_q, wr_q, rd_q, bump_q, load_ptr;
    logic [AW-1:0] ptr;

    i2c_line_cond #(.STAGES(SYNC_LEN)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    assign load_ptr = (state == ST_WORD) && (nxt == ST_WORDACK);

    i2c_ptr #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(pwr_fail), .load(load_ptr),
        .load_val(shreg), .bump(bump_q), .ptr(ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        if (pwr_fail || stop_c) begin
            nxt = ST_IDLE;
        end else if (start_c) begin
            nxt = ST_DEVADR;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_DEVADR:  if (bit_cnt == 4'd8)
                                nxt = (shreg[7:1] == DEV_ADDR) ? ST_DEVACK : ST_IDLE;
                ST_DEVACK:  nxt = shreg[0] ? ST_RDATA : ST_WORD;
                ST_WORD:    if (bit_cnt == 4'd8) nxt = ST_WORDACK;
                ST_WORDACK: nxt = ST_WDATA;
                ST_WDATA:   if (bit_cnt == 4'd8) nxt = ST_WDACK;
                ST_WDACK:   nxt = ST_WDATA;
                ST_RDATA:   if (bit_cnt == 4'd8) nxt = ST_RDACK;
                ST_RDACK:   nxt = mack ? ST_RDATA : ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // datapath beside the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            hold    <= '0;
            wdata_q <= '0;
            mack    <= 1'b0;
            sel_q   <= 1'b0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
            bump_q  <= 1'b0;
        end else begin
            wr_q   <= 1'b0;
            rd_q   <= 1'b0;
            bump_q <= 1'b0;
            if (pwr_fail) begin
                bit_cnt <= '0;
                sel_q   <= 1'b0;
            end else begin
                if (state == ST_DEVADR && nxt == ST_DEVACK) sel_q <= 1'b1;
                else if (nxt == ST_IDLE)                     sel_q <= 1'b0;

                if (start_c || nxt != state)
                    bit_cnt <= '0;
                else if (scl_rise && state inside {ST_DEVADR, ST_WORD, ST_WDATA, ST_RDATA})
                    bit_cnt <= bit_cnt + 4'd1;

                if (scl_rise && state inside {ST_DEVADR, ST_WORD, ST_WDATA})
                    shreg <= {shreg[6:0], sda_lvl};

                if (state == ST_DEVADR && nxt == ST_DEVACK && shreg[0]) rd_q <= 1'b1;
                if (bump_q && state == ST_RDACK)                        rd_q <= 1'b1;
                if (rd_q) hold <= reg_rdata;

                if (state != ST_RDATA && nxt == ST_RDATA)
                    txreg <= hold;
                else if (state == ST_RDATA && scl_fall)
                    txreg <= {txreg[6:0], 1'b0};

                if (scl_rise && state == ST_WDACK) begin
                    wr_q    <= byte_writable(8'(ptr));
                    wdata_q <= shreg;
                    bump_q  <= 1'b1;
                end
                if (scl_rise && state == ST_RDACK) begin
                    mack   <= ~sda_lvl;
                    bump_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_DEVACK, ST_WORDACK, ST_WDACK: sda_oe = 1'b1;
            ST_RDATA:                        sda_oe = ~txreg[7];
            default:                         sda_oe = 1'b0;
        endcase
    end

    assign reg_addr   = ptr;
    assign reg_wr     = wr_q;
    assign reg_wdata  = wdata_q;
    assign reg_rd     = rd_q;
    assign clk_freeze = sel_q && (ptr < AW'(FREEZE_TOP));

endmodule

// File: rtl/i2c_regfile_slave_chk.sv
`timescale 1ns/1ps
module i2c_regfile_slave_chk
    import i2c_rf_pkg::*;
#(
    parameter int MEM_BYTES  = 160,
    parameter int FREEZE_TOP = 8,
    parameter int AW         = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_fail,
    input logic          sda_oe,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          clk_freeze
);
    localparam logic [AW-1:0] LAST = AW'(MEM_BYTES - 1);

    // R8
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(reg_addr) < MEM_BYTES);

    // R9
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> byte_writable(8'(reg_addr)));

    // R3
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R4
    step_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || pwr_fail)
        reg_wr |=> reg_addr == (($past(reg_addr) == LAST) ? '0 : $past(reg_addr) + AW'(1)));

    // R11
    pwr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (reg_addr == '0 && !sda_oe && !clk_freeze));

    // R10
    freeze_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_freeze |-> int'(reg_addr) < FREEZE_TOP);

endmodule

bind i2c_regfile_slave i2c_regfile_slave_chk #(
    .MEM_BYTES(MEM_BYTES), .FREEZE_TOP(FREEZE_TOP), .AW(AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .clk_freeze(clk_freeze)
);

// File: tb/i2c_regfile_slave_bench.sv
`timescale 1ns/1ps
module i2c_regfile_slave_bench;
    localparam int Q = 50;
    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       pwr_fail = 1'b0;
    logic       sda_oe, reg_wr, reg_rd, clk_freeze;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [0:159];
    int         wr_cnt;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    i2c_regfile_slave u_i2c_regfile_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .pwr_fail(pwr_fail), .sda_oe(sda_oe), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .clk_freeze(clk_freeze)
    );

    // register-file stand-in
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 160; i++)
                mem[i] <= (i == 17) ? 8'h5A : (i == 22) ? 8'h3C : 8'h00;
            wr_cnt <= 0;
        end else if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        #H sda_m = 1'b1; #H scl_m = 1'b1; #Q sda_m = 1'b0; #Q scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        #H sda_m = 1'b0; #H scl_m = 1'b1; #Q sda_m = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            #H sda_m = b[i]; #Q scl_m = 1'b1; #Q scl_m = 1'b0;
        end
        #H sda_m = 1'b1; #Q scl_m = 1'b1; #(Q/2) acked = ~sda_bus; #(Q/2) scl_m = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            #H sda_m = 1'b1; #Q scl_m = 1'b1; #(Q/2) d[i] = sda_bus; #(Q/2) scl_m = 1'b0;
        end
        #H sda_m = ~give_ack; #Q scl_m = 1'b1; #Q scl_m = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 sda_oe", int'(sda_oe), 0);
        chk("R12 freeze", int'(clk_freeze), 0);
        chk("R12 pointer", int'(reg_addr), 0);
    endtask

    // R1 R2 R3 R4: write burst of four bytes at 20h
    task automatic t_write_burst();
        logic a;
        int base = wr_cnt;
        bus_start();
        send_byte(8'hD0, a); chk("R2 ack D0", int'(a), 1);
        send_byte(8'h20, a); chk("R3 ack word", int'(a), 1);
        send_byte(8'h11, a); chk("R3 ack data", int'(a), 1);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        send_byte(8'h44, a); chk("R3 ack last", int'(a), 1);
        bus_stop();
        chk("R3 mem20", int'(mem[8'h20]), 8'h11);
        chk("R3 mem23", int'(mem[8'h23]), 8'h44);
        chk("R3 strobes", wr_cnt - base, 4);
        chk("R4 pointer after write", int'(reg_addr), 8'h24);
    endtask

    // R5 R1: random read via repeated START
    task automatic t_random_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h20, a);
        bus_start();
        send_byte(8'hD1, a); chk("R2 ack D1", int'(a), 1);
        recv_byte(1'b1, d); chk("R5 first byte", int'(d), 8'h11);
        recv_byte(1'b1, d); chk("R5 second byte", int'(d), 8'h22);
        recv_byte(1'b0, d); chk("R5 third byte", int'(d), 8'h33);
        bus_stop();
        chk("R4 pointer after read", int'(reg_addr), 8'h23);
    endtask

    // R6 R7: current-address read with NACK
    task automatic t_current_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(1'b0, d); chk("R6 current byte", int'(d), 8'h44);
        #H chk("R7 sda released", int'(sda_oe), 0);
        chk("R7 freeze low", int'(clk_freeze), 0);
        bus_stop();
        chk("R4 nack clock advances", int'(reg_addr), 8'h24);
    endtask

    // R2: foreign device address
    task automatic t_foreign();
        logic a;
        int base = wr_cnt;
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign nack", int'(a), 0);
        send_byte(8'h55, a); chk("R2 ignored byte", int'(a), 0);
        bus_stop();
        chk("R2 no strobe", wr_cnt - base, 0);
    endtask

    // R9: protected windows
    task automatic t_protect();
        logic a;
        int base = wr_cnt;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h10, a);
        send_byte(8'h01, a); chk("R9 ack locked", int'(a), 1);
        send_byte(8'h02, a);
        send_byte(8'h03, a);
        bus_stop();
        chk("R9 mem11 kept", int'(mem[8'h11]), 8'h5A);
        chk("R9 pointer moved", int'(reg_addr), 8'h13);
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h15, a);
        send_byte(8'h77, a);
        send_byte(8'h88, a); chk("R9 ack id", int'(a), 1);
        bus_stop();
        chk("R9 mem15 written", int'(mem[8'h15]), 8'h77);
        chk("R9 mem16 kept", int'(mem[8'h16]), 8'h3C);
        chk("R9 strobe count", wr_cnt - base, 1);
    endtask

    // R8: wrap and out-of-range word address
    task automatic t_wrap();
        logic a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h9F, a);
        send_byte(8'hAA, a);
        send_byte(8'hBB, a);
        bus_stop();
        chk("R8 mem9F", int'(mem[8'h9F]), 8'hAA);
        chk("R8 mem00", int'(mem[8'h00]), 8'hBB);
        chk("R8 pointer wrapped", int'(reg_addr), 8'h01);
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'hC8, a); chk("R8 ack high word", int'(a), 1);
        bus_stop();
        chk("R8 high word loads 0", int'(reg_addr), 0);
    endtask

    // R10: freeze window
    task automatic t_freeze();
        logic a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h06, a); chk("R10 freeze at 06", int'(clk_freeze), 1);
        send_byte(8'h61, a); chk("R10 freeze at 07", int'(clk_freeze), 1);
        send_byte(8'h62, a); chk("R10 free at 08", int'(clk_freeze), 0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h02, a); chk("R10 freeze at 02", int'(clk_freeze), 1);
        bus_stop();
        chk("R10 free after stop", int'(clk_freeze), 0);
    endtask

    // R11: power fail partway through a write
    task automatic t_power_fail();
        logic a;
        int base = wr_cnt;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h30, a);
        send_byte(8'h99, a);
        pwr_fail = 1'b1;
        #100;
        chk("R11 pointer cleared", int'(reg_addr), 0);
        chk("R11 sda released", int'(sda_oe), 0);
        send_byte(8'h12, a); chk("R11 no ack during fail", int'(a), 0);
        pwr_fail = 1'b0;
        #50;
        send_byte(8'h34, a); chk("R11 no ack after abort", int'(a), 0);
        bus_stop();
        chk("R11 mem30", int'(mem[8'h30]), 8'h99);
        chk("R11 mem31 untouched", int'(mem[8'h31]), 0);
        chk("R11 strobe count", wr_cnt - base, 1);
    endtask

    initial begin
        #40 rst_n = 1'b1;
        #20;
        t_reset();
        t_write_burst();
        t_random_read();
        t_current_read();
        t_foreign();
        t_protect();
        t_wrap();
        t_freeze();
        t_power_fail();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule